// File: doc/BRIEF.md
# Serial Framed Parity Inserter

This block sits on a serial stream that carries one bit per clock and is grouped into messages of exactly three data bits. It passes each accepted data bit through to its serial output one cycle later. After the third data bit of a message it adds one more output slot carrying an even-parity bit, so the three data bits and the parity bit together always hold an even number of ones. Every three input data bits therefore become four output slots.

A small state machine tracks the position within the current message and the running parity. After the third data bit, the next clock cycle is reserved for the parity bit. Any input offered in that cycle is dropped. Once the parity bit has gone out, the position and the running parity both go back to zero, so each message is checked on its own. The upstream source may leave idle cycles (valid low) between data bits. These gaps produce idle output cycles and do not move the message position. A synchronous reset puts the block back at the start of a message.

Top module: `par_frame_inserter`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `out_valid`=0, `out_parity_slot`=0 and `out_bit`=0, and the next accepted bit is treated as the first bit of a message.
- R2: A data bit offered with `in_valid`=1 outside the parity slot is accepted. After the next rising edge the outputs show `out_valid`=1, `out_parity_slot`=0 and `out_bit` equal to that input bit.
- R3: The edge that follows the acceptance of the third data bit of a message is the parity slot. After that edge the outputs show `out_valid`=1, `out_parity_slot`=1 and `out_bit` equal to the XOR of the three data bits, which is even parity.
- R4: An edge with `in_valid`=0 outside the parity slot gives `out_valid`=0 afterwards and leaves the message position unchanged.
- R5: The values of `in_valid` and `in_bit` at the parity-slot edge are ignored. No extra output is produced and the message position does not advance.
- R6: After the parity slot, the position and the running parity return to zero. Each message's parity depends only on its own three data bits.
- R7: `out_parity_slot` is high only together with `out_valid`, never in two consecutive cycles, and exactly once per message, after the third data output.
- R8: A reset in the middle of a message discards the bits accepted so far. The next message's parity covers only the bits accepted after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Serial data input bit |
| in_valid | input | 1 | High when `in_bit` carries a data bit |
| out_bit | output | 1 | Serial output: a data bit or the parity bit |
| out_parity_slot | output | 1 | High in the cycle in which `out_bit` carries parity |
| out_valid | output | 1 | High when `out_bit` carries a slot |

## Verification
The checker watches every cycle for three things: that an accepted bit reappears one cycle later as a data slot, that the third accepted bit is always followed by a parity slot, and that the slot flag never stands alone or repeats. It also checks that position and parity are zero after each slot and that idle edges produce idle outputs. The value of the parity bit depends on the whole message history, so it is shown only by the bench scenarios. These cover all eight data patterns, gaps inside a message, input dropped during the slot, back-to-back messages and a reset in mid-message.

// File: rtl/par_frame_pkg.sv
package par_frame_pkg;
  // data bits per message; the message length is fixed by the block's function
  localparam int unsigned MSG_BITS = 3;
  localparam int unsigned POS_W    = $clog2(MSG_BITS + 1);

  typedef logic [POS_W-1:0] pos_t;

  // running even parity: fold one more data bit into the accumulator
  function automatic logic par_fold(input logic acc, input logic b);
    return acc ^ b;
  endfunction

  // the position after the last data bit is the parity slot
  function automatic logic pos_is_slot(input pos_t p);
    return p == pos_t'(MSG_BITS);
  endfunction

  function automatic pos_t pos_advance(input pos_t p);
    return p + pos_t'(1);
  endfunction
endpackage

// File: rtl/frame_pos_ctr.sv
module frame_pos_ctr
  import par_frame_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic slot_now,
  output pos_t pos
);
  pos_t pos_q;

  always_ff @(posedge clk) begin
    if (rst)           pos_q <= '0;
    else if (slot_now) pos_q <= '0;
    else if (accept)   pos_q <= pos_advance(pos_q);
  end

  assign pos = pos_q;
endmodule

// File: rtl/parity_acc.sv
module parity_acc
  import par_frame_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic data_bit,
  input  logic clear,
  output logic acc
);
  logic acc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= 1'b0;
    else if (accept)  acc_q <= par_fold(acc_q, data_bit);
  end

  assign acc = acc_q;
endmodule

// File: rtl/serial_out_stage.sv
module serial_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic slot_now,
  input  logic data_bit,
  input  logic par_bit,
  output logic out_bit,
  output logic out_parity_slot,
  output logic out_valid
);
  logic bit_q, slot_q, vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= 1'b0;
      slot_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (slot_now) begin
      bit_q  <= par_bit;
      slot_q <= 1'b1;
      vld_q  <= 1'b1;
    end else if (accept) begin
      bit_q  <= data_bit;
      slot_q <= 1'b0;
      vld_q  <= 1'b1;
    end else begin
      bit_q  <= 1'b0;
      slot_q <= 1'b0;
      vld_q  <= 1'b0;
    end
  end

  assign out_bit         = bit_q;
  assign out_parity_slot = slot_q;
  assign out_valid       = vld_q;
endmodule

// File: rtl/par_frame_inserter.sv
module par_frame_inserter
  import par_frame_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_bit,
  input  logic in_valid,
  output logic out_bit,
  output logic out_parity_slot,
  output logic out_valid
);
  pos_t pos;
  logic par_acc;
  logic slot_now;  // this edge emits the parity bit
  logic accept;    // this edge takes in a data bit

  assign slot_now = pos_is_slot(pos);
  assign accept   = in_valid && !slot_now;

  frame_pos_ctr u_pos (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .slot_now (slot_now),
    .pos      (pos)
  );

  parity_acc u_par (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .data_bit (in_bit),
    .clear    (slot_now),
    .acc      (par_acc)
  );

  serial_out_stage u_out (
    .clk             (clk),
    .rst             (rst),
    .accept          (accept),
    .slot_now        (slot_now),
    .data_bit        (in_bit),
    .par_bit         (par_acc),
    .out_bit         (out_bit),
    .out_parity_slot (out_parity_slot),
    .out_valid       (out_valid)
  );
endmodule

// File: rtl/par_frame_inserter_chk.sv
module par_frame_inserter_chk
  import par_frame_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic in_bit,
  input logic accept,
  input logic slot_now,
  input pos_t pos,
  input logic par_acc,
  input logic out_bit,
  input logic out_parity_slot,
  input logic out_valid
);
  // R2
  data_pass_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (out_valid && !out_parity_slot && out_bit == $past(in_bit)));

  // R3
  slot_after_third_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && pos == pos_t'(MSG_BITS - 1)) |=> slot_now);

  // R3
  slot_flag_follows_chk: assert property (@(posedge clk) disable iff (rst)
    slot_now |=> (out_parity_slot && out_valid));

  // R4
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept && !slot_now) |=> (!out_valid && $stable(pos)));

  // R5
  slot_no_advance_chk: assert property (@(posedge clk) disable iff (rst)
    slot_now |-> !accept);

  // R6
  frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
    slot_now |=> (pos == '0 && !par_acc));

  // R7
  slot_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_parity_slot |-> out_valid);

  // R7
  slot_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_parity_slot |=> !out_parity_slot);
endmodule

bind par_frame_inserter par_frame_inserter_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .in_bit          (in_bit),
  .accept          (accept),
  .slot_now        (slot_now),
  .pos             (pos),
  .par_acc         (par_acc),
  .out_bit         (out_bit),
  .out_parity_slot (out_parity_slot),
  .out_valid       (out_valid)
);

// File: tb/sim_par_frame_inserter.sv
`timescale 1ns/1ps
module sim_par_frame_inserter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_bit = 1'b0;
  logic in_valid = 1'b0;
  logic out_bit, out_parity_slot, out_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  par_frame_inserter u0 (
    .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
    .out_bit(out_bit), .out_parity_slot(out_parity_slot), .out_valid(out_valid)
  );

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: valid/slot/bit actual %b expected %b", tag, act, exp);
    end
  endtask

  // drive one edge and compare {valid, slot, bit} after it
  task automatic step(input logic v, input logic b, input logic [2:0] exp, input string tag);
    @(negedge clk);
    in_valid = v;
    in_bit   = b;
    @(posedge clk);
    #1;
    chk({out_valid, out_parity_slot, out_bit}, exp, tag);
  endtask

  task automatic t_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    @(posedge clk);
    #1;
    chk({out_valid, out_parity_slot, out_bit}, 3'b000, tag);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  // one full message; the parity edge is offered junk input that must be dropped
  task automatic t_message(input logic [2:0] d, input logic junk);
    step(1'b1, d[0], {2'b10, d[0]}, "R2 data0");
    step(1'b1, d[1], {2'b10, d[1]}, "R2 data1");
    step(1'b1, d[2], {2'b10, d[2]}, "R7 data2 no slot");
    step(junk, junk, {2'b11, ^d}, "R3 parity");
  endtask

  task automatic t_all_patterns;
    for (int p = 0; p < 8; p++) t_message(p[2:0], 1'b0);
  endtask

  task automatic t_gaps;
    step(1'b1, 1'b1, 3'b101, "R2 gap msg d0");
    step(1'b0, 1'b1, 3'b000, "R4 idle");
    step(1'b0, 1'b0, 3'b000, "R4 idle");
    step(1'b1, 1'b1, 3'b101, "R4 position held d1");
    step(1'b0, 1'b0, 3'b000, "R4 idle");
    step(1'b1, 1'b0, 3'b100, "R4 d2");
    step(1'b0, 1'b0, 3'b110, "R3 parity after gaps");
    step(1'b0, 1'b0, 3'b000, "R7 slot not repeated");
  endtask

  task automatic t_ignore;
    t_message(3'b011, 1'b1);
    step(1'b0, 1'b0, 3'b000, "R5 dropped bit gives no output");
    // if the dropped bit had counted, parity would come after two bits
    step(1'b1, 1'b1, 3'b101, "R5 d0");
    step(1'b1, 1'b0, 3'b100, "R5 d1");
    step(1'b1, 1'b0, 3'b100, "R5 d2 not slot");
    step(1'b0, 1'b0, 3'b111, "R5 parity position");
  endtask

  task automatic t_indep;
    t_message(3'b001, 1'b0);
    step(1'b1, 1'b0, 3'b100, "R6 d0");
    step(1'b1, 1'b0, 3'b100, "R6 d1");
    step(1'b1, 1'b0, 3'b100, "R6 d2");
    step(1'b0, 1'b0, 3'b110, "R6 parity fresh");
  endtask

  task automatic t_mid_reset;
    step(1'b1, 1'b1, 3'b101, "R8 pre d0");
    step(1'b1, 1'b0, 3'b100, "R8 pre d1");
    t_reset("R8 reset mid message");
    step(1'b1, 1'b0, 3'b100, "R8 d0");
    step(1'b1, 1'b1, 3'b101, "R8 d1");
    step(1'b1, 1'b0, 3'b100, "R8 d2");
    step(1'b0, 1'b0, 3'b111, "R8 parity of post-reset bits");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset("R1 reset state");
    t_all_patterns();
    t_gaps();
    t_ignore();
    t_indep();
    t_mid_reset();
    step(1'b0, 1'b0, 3'b000, "R1 idle after run");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule